// File: doc/BRIEF.md
# Acquisition Trigger Sequencer

This block sits between a sample-rate enable and a pattern acquisition or generation engine and decides, cycle by cycle, whether the engine may move a sample. The engine sees one transfer-enable output. That output is high only in a cycle where the sample-rate enable is high and the selected trigger mode allows a transfer.

An operation begins with a software start strobe. Three modes are available. In single-shot mode, one trigger releases one burst of the programmed length. In repeated-trigger mode, each trigger releases one burst, and the block re-arms after each burst until the programmed number of triggers has been served. In pause-gated mode, the external line acts as a pause input: while it is high, transfers stop, and the operation ends once the total programmed count has moved.

The trigger for a burst is either the software strobe itself or a chosen edge of the external line. The external line is synchronized inside the block. Accepting a start also launches a trigger-out pulse whose width is counted in clock cycles; one cycle is the 8 ns unit at the intended clock rate.

Top module: `trig_seq_top`

## Requirements
- R1: While reset is held and in the cycle after it is released, `busy`, `xfer_en`, `done` and `trig_out` are all low.
- R2: `xfer_en` is high only in cycles where `sample_en` is high. With `use_ext` low and `mode` 2'b00 (single-shot), a software start from idle releases exactly `sample_count` transfers at once, without waiting for the external line.
- R3: With `use_ext` high, the block stays busy and passes no transfer until the external line shows the selected edge: rising when `fall_edge` is 0, falling when it is 1. The opposite edge is ignored. The line passes through a two-flop synchronizer before edge detection.
- R4: With `mode` 2'b01 (repeated-trigger), each trigger releases `sample_count` transfers, and the block re-arms after each burst until `retrig_count` bursts have completed. Trigger edges that arrive while a burst is running are ignored.
- R5: With `mode` 2'b10 (pause-gated), transfers run from the start. They stop while the synchronized `ext_trig` is high and resume when it goes low. The operation ends after `sample_count` transfers in total.
- R6: `done` is high for exactly one cycle, in the same cycle as the final transfer of the operation. `busy` is low in the following cycle.
- R7: A start accepted from idle drives `trig_out` high for `pulse_width`+1 consecutive cycles, beginning in the next cycle.
- R8: While `busy` is high, a software start launches no trigger-out pulse and reloads no count. In single-shot mode with external triggering, it also does not trigger a burst.
- R9: A `sample_count` of zero is treated as one transfer, and a `retrig_count` of zero is treated as one burst. `mode` 2'b11 behaves as single-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample-rate enable from the clock divider |
| sw_start | input | 1 | Software start strobe, one cycle |
| ext_trig | input | 1 | Asynchronous external trigger / pause line |
| mode | input | 2 | 00 single-shot, 01 repeated-trigger, 10 pause-gated, 11 as 00 |
| use_ext | input | 1 | 1: bursts wait for an external edge; 0: the software strobe is the trigger |
| fall_edge | input | 1 | 1: falling edge is active; 0: rising edge |
| sample_count | input | CNT_W | Transfers per burst (total transfers in pause-gated mode) |
| retrig_count | input | TRIG_W | Number of bursts in repeated-trigger mode |
| pulse_width | input | PW_W | Trigger-out width minus one, in cycles |
| xfer_en | output | 1 | Per-sample transfer enable to the engine |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse with the final transfer |
| trig_out | output | 1 | Trigger-out pulse |

## Verification
The hardest case to reach is a trigger edge that arrives while a burst is still running. The edge must first pass the synchronizer, and it must be detected inside the window in which the block is counting samples. The stimulus drops the external line and raises it again a few cycles after the first edge. With an 8-sample burst, the second rising edge leaves the synchronizer well before the burst ends. The expected transfer total stays at one burst until a later, separate edge arrives.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_REPEAT = 2'b01,
        MODE_GATED  = 2'b10,
        MODE_RSVD   = 2'b11
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_BURST = 2'b10,
        ST_PAUSE = 2'b11
    } seq_state_e;

    // synchronized view of the external line
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_evt_t;

    // pick the active edge of the synchronized line
    function automatic logic pick_edge(line_evt_t e, logic falling);
        return falling ? e.fall : e.rise;
    endfunction

endpackage

// File: rtl/trig_sync_edge.sv
module trig_sync_edge
    import trig_seq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    output line_evt_t evt
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        evt.level = chain[STAGES-1];
        evt.rise  = chain[STAGES-1] & ~prev;
        evt.fall  = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
    parameter int PW_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic [PW_W-1:0] width,
    output logic            pulse
);
    logic [PW_W-1:0] left;
    logic            active;

    always_ff @(posedge clk) begin
        if (rst) begin
            left   <= '0;
            active <= 1'b0;
        end else if (fire) begin
            left   <= width;
            active <= 1'b1;
        end else if (active) begin
            if (left == '0) begin
                active <= 1'b0;
            end else begin
                left <= left - 1'b1;
            end
        end
    end

    assign pulse = active;
endmodule

// File: rtl/trig_burst_ctrl.sv
module trig_burst_ctrl
    import trig_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int TRIG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_ok,
    input  logic              sw_start,
    input  trig_mode_e        mode_in,
    input  logic              use_ext,
    input  logic              fall_edge,
    input  line_evt_t         evt,
    input  logic              sample_en,
    input  logic [CNT_W-1:0]  sample_count,
    input  logic [TRIG_W-1:0] retrig_count,
    output logic              xfer_en,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [TRIG_W-1:0] TRIG_ONE = TRIG_W'(1);

    seq_state_e        state;
    logic [CNT_W-1:0]  burst_len;
    logic [CNT_W-1:0]  samp_left;
    logic [TRIG_W-1:0] trig_left;
    logic              ext_q;
    logic              fall_q;

    logic [CNT_W-1:0]  cnt_eff;
    logic [TRIG_W-1:0] trg_eff;
    logic              trig_hit;
    logic              last_samp;

    always_comb begin
        cnt_eff = (sample_count == '0) ? CNT_ONE : sample_count;
        if (mode_in == MODE_REPEAT) begin
            trg_eff = (retrig_count == '0) ? TRIG_ONE : retrig_count;
        end else begin
            trg_eff = TRIG_ONE;
        end
        trig_hit  = ext_q ? pick_edge(evt, fall_q) : sw_start;
        xfer_en   = sample_en &&
                    ((state == ST_BURST) || ((state == ST_PAUSE) && !evt.level));
        last_samp = (samp_left == CNT_ONE) &&
                    ((state == ST_PAUSE) || (trig_left == TRIG_ONE));
        done      = xfer_en && last_samp;
        busy      = (state != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            burst_len <= '0;
            samp_left <= '0;
            trig_left <= '0;
            ext_q     <= 1'b0;
            fall_q    <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        burst_len <= cnt_eff;
                        samp_left <= cnt_eff;
                        trig_left <= trg_eff;
                        ext_q     <= use_ext;
                        fall_q    <= fall_edge;
                        if (mode_in == MODE_GATED) begin
                            state <= ST_PAUSE;
                        end else if (use_ext) begin
                            state <= ST_ARMED;
                        end else begin
                            state <= ST_BURST;
                        end
                    end
                end
                ST_ARMED: begin
                    if (trig_hit) begin
                        samp_left <= burst_len;
                        state     <= ST_BURST;
                    end
                end
                ST_BURST: begin
                    if (xfer_en) begin
                        if (samp_left == CNT_ONE) begin
                            if (trig_left == TRIG_ONE) begin
                                state <= ST_IDLE;
                            end else begin
                                trig_left <= trig_left - 1'b1;
                                state     <= ST_ARMED;
                            end
                        end else begin
                            samp_left <= samp_left - 1'b1;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (xfer_en) begin
                        if (samp_left == CNT_ONE) begin
                            state <= ST_IDLE;
                        end else begin
                            samp_left <= samp_left - 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/trig_seq_top.sv
module trig_seq_top
    import trig_seq_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int TRIG_W    = 8,
    parameter int PW_W      = 32,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_en,
    input  logic              sw_start,
    input  logic              ext_trig,
    input  logic [1:0]        mode,
    input  logic              use_ext,
    input  logic              fall_edge,
    input  logic [CNT_W-1:0]  sample_count,
    input  logic [TRIG_W-1:0] retrig_count,
    input  logic [PW_W-1:0]   pulse_width,
    output logic              xfer_en,
    output logic              busy,
    output logic              done,
    output logic              trig_out
);
    line_evt_t  line_evt;
    logic       start_ok;
    logic       busy_i;
    trig_mode_e mode_e;

    assign mode_e   = trig_mode_e'(mode);
    assign start_ok = sw_start && !busy_i;
    assign busy     = busy_i;

    trig_sync_edge #(.STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (ext_trig),
        .evt (line_evt)
    );

    trig_burst_ctrl #(.CNT_W(CNT_W), .TRIG_W(TRIG_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_ok     (start_ok),
        .sw_start     (sw_start),
        .mode_in      (mode_e),
        .use_ext      (use_ext),
        .fall_edge    (fall_edge),
        .evt          (line_evt),
        .sample_en    (sample_en),
        .sample_count (sample_count),
        .retrig_count (retrig_count),
        .xfer_en      (xfer_en),
        .busy         (busy_i),
        .done         (done)
    );

    trig_pulse_gen #(.PW_W(PW_W)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (start_ok),
        .width (pulse_width),
        .pulse (trig_out)
    );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
    input logic clk,
    input logic rst,
    input logic sample_en,
    input logic sw_start,
    input logic xfer_en,
    input logic busy,
    input logic done,
    input logic trig_out
);
    AST_XFER_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        xfer_en |-> (sample_en && busy)); // R2

    AST_DONE_WITH_XFER: assert property (@(posedge clk) disable iff (rst)
        done |-> xfer_en); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R6

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R6

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        (sw_start && !busy) |=> (trig_out && busy)); // R7

    AST_NO_PULSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && !trig_out) |=> !$rose(trig_out)); // R8
endmodule

bind trig_seq_top trig_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sample_en),
    .sw_start  (sw_start),
    .xfer_en   (xfer_en),
    .busy      (busy),
    .done      (done),
    .trig_out  (trig_out)
);

// File: tb/trig_seq_top_tb.sv
module trig_seq_top_tb;
    localparam int CLK_P  = 8;
    localparam int CNT_W  = 16;
    localparam int TRIG_W = 8;
    localparam int PW_W   = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_en = 1'b1;
    logic              en_toggle = 1'b0;
    logic              sw_start = 1'b0;
    logic              ext_trig = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              use_ext = 1'b0;
    logic              fall_edge = 1'b0;
    logic [CNT_W-1:0]  sample_count = '0;
    logic [TRIG_W-1:0] retrig_count = '0;
    logic [PW_W-1:0]   pulse_width = '0;
    logic              xfer_en;
    logic              busy;
    logic              done;
    logic              trig_out;

    int n_cmp = 0;
    int n_bad = 0;
    int n_xfer = 0;
    int n_done = 0;
    int n_trig = 0;
    int n_xfer_noen = 0;
    int n_done_noxfer = 0;
    int n_busy_after = 0;
    logic prev_done = 1'b0;
    logic finished = 1'b0;

    trig_seq_top #(.CNT_W(CNT_W), .TRIG_W(TRIG_W), .PW_W(PW_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .sample_en    (sample_en),
        .sw_start     (sw_start),
        .ext_trig     (ext_trig),
        .mode         (mode),
        .use_ext      (use_ext),
        .fall_edge    (fall_edge),
        .sample_count (sample_count),
        .retrig_count (retrig_count),
        .pulse_width  (pulse_width),
        .xfer_en      (xfer_en),
        .busy         (busy),
        .done         (done),
        .trig_out     (trig_out)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        sample_en = en_toggle ? ~sample_en : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (xfer_en) n_xfer++;
            if (done) n_done++;
            if (trig_out) n_trig++;
            if (xfer_en && !sample_en) n_xfer_noen++;
            if (done && !xfer_en) n_done_noxfer++;
            if (prev_done && busy) n_busy_after++;
            prev_done = done;
        end
    end

    task automatic check(string req, int actual, int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_start();
        sw_start = 1'b1;
        tick(1);
        sw_start = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(3);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 xfer_en in reset", int'(xfer_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy after release", int'(busy), 0);
        check("R1 done/trig_out after release", int'(done | trig_out), 0);
        tick(1);
    endtask

    task automatic t_sw_single();
        int bx = n_xfer, bd = n_done, bt = n_trig;
        mode = 2'b00; use_ext = 1'b0; sample_count = 16'd5; pulse_width = 32'd3;
        pulse_start();
        tick(20);
        check("R2 sw single-shot transfers", n_xfer - bx, 5);
        check("R6 one done per operation", n_done - bd, 1);
        check("R7 trig_out width 3+1", n_trig - bt, 4);
        check("R6 busy low at end", int'(busy), 0);
    endtask

    task automatic t_toggle_en();
        int bx = n_xfer;
        en_toggle = 1'b1;
        mode = 2'b00; use_ext = 1'b0; sample_count = 16'd6;
        pulse_start();
        tick(40);
        en_toggle = 1'b0;
        tick(2);
        check("R2 transfers under toggling enable", n_xfer - bx, 6);
        check("R2 no transfer without sample_en", n_xfer_noen, 0);
    endtask

    task automatic t_ext_rise();
        int bx = n_xfer;
        mode = 2'b00; use_ext = 1'b1; fall_edge = 1'b0; sample_count = 16'd4;
        ext_trig = 1'b0;
        pulse_start();
        tick(10);
        check("R3 no transfer before edge", n_xfer - bx, 0);
        check("R3 busy while armed", int'(busy), 1);
        ext_trig = 1'b1;
        tick(15);
        check("R3 transfers after rising edge", n_xfer - bx, 4);
        ext_trig = 1'b0;
        tick(5);
        check("R3 idle after burst", int'(busy), 0);
    endtask

    task automatic t_ext_fall();
        int bx = n_xfer;
        mode = 2'b00; use_ext = 1'b1; fall_edge = 1'b1; sample_count = 16'd3;
        ext_trig = 1'b0;
        tick(4);
        pulse_start();
        tick(3);
        ext_trig = 1'b1;
        tick(10);
        check("R3 rising edge ignored when falling selected", n_xfer - bx, 0);
        ext_trig = 1'b0;
        tick(12);
        check("R3 transfers after falling edge", n_xfer - bx, 3);
        check("R3 idle after falling-edge burst", int'(busy), 0);
        fall_edge = 1'b0;
    endtask

    task automatic t_repeat();
        int bx = n_xfer, bd = n_done;
        mode = 2'b01; use_ext = 1'b1; fall_edge = 1'b0;
        sample_count = 16'd4; retrig_count = 8'd3;
        pulse_start();
        for (int k = 0; k < 3; k++) begin
            tick(3);
            ext_trig = 1'b1;
            tick(2);
            ext_trig = 1'b0;
            tick(12);
            check("R4 cumulative transfers per trigger", n_xfer - bx, 4 * (k + 1));
            check("R4 busy until last burst", int'(busy), (k < 2) ? 1 : 0);
        end
        check("R4 one done over all bursts", n_done - bd, 1);
    endtask

    task automatic t_repeat_ignore();
        int bx = n_xfer;
        mode = 2'b01; use_ext = 1'b1; fall_edge = 1'b0;
        sample_count = 16'd8; retrig_count = 8'd2;
        pulse_start();
        tick(3);
        ext_trig = 1'b1;
        tick(3);
        ext_trig = 1'b0;
        tick(2);
        ext_trig = 1'b1;
        tick(2);
        ext_trig = 1'b0;
        tick(15);
        check("R4 edge during burst ignored", n_xfer - bx, 8);
        check("R4 still armed for second trigger", int'(busy), 1);
        ext_trig = 1'b1;
        tick(2);
        ext_trig = 1'b0;
        tick(15);
        check("R4 second burst after fresh edge", n_xfer - bx, 16);
        check("R4 idle after two bursts", int'(busy), 0);
    endtask

    task automatic t_gated();
        int bx = n_xfer, bd = n_done, snap;
        mode = 2'b10; use_ext = 1'b0; sample_count = 16'd12;
        ext_trig = 1'b0;
        pulse_start();
        tick(3);
        ext_trig = 1'b1;
        tick(4);
        snap = n_xfer;
        tick(10);
        check("R5 no transfer while paused", n_xfer - snap, 0);
        check("R5 busy while paused", int'(busy), 1);
        ext_trig = 1'b0;
        tick(20);
        check("R5 total transfers after resume", n_xfer - bx, 12);
        check("R5 done once", n_done - bd, 1);
        check("R5 idle at end", int'(busy), 0);
    endtask

    task automatic t_zero_counts();
        int bx = n_xfer;
        mode = 2'b00; use_ext = 1'b0; sample_count = 16'd0;
        pulse_start();
        tick(8);
        check("R9 zero sample count gives one transfer", n_xfer - bx, 1);
        bx = n_xfer;
        mode = 2'b01; sample_count = 16'd2; retrig_count = 8'd0;
        pulse_start();
        tick(8);
        check("R9 zero trigger count gives one burst", n_xfer - bx, 2);
        check("R9 idle after single burst", int'(busy), 0);
        bx = n_xfer;
        mode = 2'b11; sample_count = 16'd3; retrig_count = 8'd4;
        pulse_start();
        tick(10);
        check("R9 reserved mode acts as single-shot", n_xfer - bx, 3);
        check("R9 reserved mode ends", int'(busy), 0);
    endtask

    task automatic t_busy_start();
        int bx = n_xfer, bt = n_trig;
        mode = 2'b00; use_ext = 1'b1; fall_edge = 1'b0;
        sample_count = 16'd4; pulse_width = 32'd2;
        pulse_start();
        tick(10);
        check("R7 trig_out width 2+1", n_trig - bt, 3);
        sample_count = 16'd9;
        pulse_start();
        tick(10);
        check("R8 no pulse on busy start", n_trig - bt, 3);
        check("R8 busy start gives no transfer", n_xfer - bx, 0);
        check("R8 still busy", int'(busy), 1);
        ext_trig = 1'b1;
        tick(15);
        ext_trig = 1'b0;
        check("R8 counts not reloaded", n_xfer - bx, 4);
        tick(3);
    endtask

    task automatic t_width_min();
        int bt = n_trig;
        mode = 2'b00; use_ext = 1'b0; sample_count = 16'd2; pulse_width = 32'd0;
        pulse_start();
        tick(8);
        check("R7 minimum trig_out width", n_trig - bt, 1);
        bt = n_trig;
        pulse_width = 32'd6;
        pulse_start();
        tick(12);
        check("R7 trig_out width 6+1", n_trig - bt, 7);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            check("R6 done only with a transfer", n_done_noxfer, 0);
            check("R6 busy low after done", n_busy_after, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_sw_single();
        t_toggle_en();
        t_ext_rise();
        t_ext_fall();
        t_repeat();
        t_repeat_ignore();
        t_gated();
        t_zero_counts();
        t_busy_start();
        t_width_min();
        finish_run();
    end

    initial begin
        #(CLK_P * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule